// File: doc/BRIEF.md
# Averaging Multi-Channel ADC Sequencer

This block is a register-mapped controller placed in front of a 12-bit successive-approximation converter core. The core is seen only through a request/acknowledge sample port. Four logical channels, numbered 0 to 3, can each be pointed at any one of sixteen physical inputs.

Arming a channel runs one burst of conversions. When averaging is on, the burst takes 4, 8, 16 or 32 samples. The samples are summed in an accumulator and the sum is divided by a right shift. The 12-bit mean is stored in a result register that is shared by two channels, and a done flag is raised. A prescaled tick paces the samples and also bounds the wait for each acknowledge. If the acknowledge does not come in time, the burst is abandoned and a timeout flag is raised. Status flags stay set until software writes zero to them. The interrupt line is the OR of every flag that is enabled in both enable registers.

Software programs the prescaler and the pacing value, enables the interrupts and powers up the block. It then arms a channel and waits for the interrupt.

Top module: `avg_adc_ctrl`

## Requirements
- R1: After reset the global register (0x130) reads 0x8000_0002: clock-down at bit 31 and power-down at bit 1 are set, and enable at bit 0 is clear. The status register (0xE0), both result registers and `irq_o` read zero.
- R2: No burst starts, and `smp_req_o` stays low, unless the global register has bit 0 set and bits 1 and 31 clear. An armed channel stays armed while it waits.
- R3: The configuration register at 0x20·n holds the arm bit (31), single-shot (30), average enable (29) and input select (27:24). The register at 0x20·n+0x10 holds the sample count at bits 13:12, where codes 0 to 3 give 4, 8, 16 and 32 samples. With averaging on, the result is the sum of the samples shifted right by log2 of the count, and `smp_sel_o` carries the select value.
- R4: With averaging off, a burst takes exactly one sample and stores it unchanged.
- R5: The register at 0xF0 holds channel 0 in bits 11:0 and channel 1 in bits 27:16. The register at 0x100 holds channels 2 and 3 in the same layout, and all other bits read zero.
- R6: When a burst completes, the done flag for channel n (status bit 8+n) is set and the arm bit of that channel is cleared.
- R7: Reading the status register does not change it. A write clears exactly the bits written as 0 and leaves the bits written as 1 unchanged.
- R8: `irq_o` is high only while some status flag for channel n (bit 8+n or bit 16+n) is set and bit 8+n is set in both the signal-enable register (0xC0) and the interrupt-enable register (0xD0).
- R9: When several channels are armed together, they are served one burst at a time in ascending order, channel 0 first.
- R10: If no acknowledge arrives within TMO_TICKS prescaled ticks of a request, status bit 16+n is set, the arm bit is cleared, no done flag is set and the stored result is left unchanged.
- R11: The timer register (0x90) selects the tick divider at bits 31:29, where codes 0 to 5 divide by 4 to 128 and codes 6 and 7 divide by 128. Its low bits hold a unit value u. Consecutive sample requests within a burst are spaced by (u+1)·6 ticks, plus the acknowledge latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| smp_req_o | output | 1 | Sample request to the converter core |
| smp_sel_o | output | 4 | Physical input being sampled |
| smp_ack_i | input | 1 | One-cycle sample acknowledge |
| smp_data_i | input | SMP_W | Sample value, valid with smp_ack_i |
| irq_o | output | 1 | Interrupt request |

## Verification
A corrupted accumulator or shift count shows up at the port as a wrong mean, read back on the very first interrupt. Because every input is driven with a ramp of distinct sample values, a dropped or repeated sample changes the result. A sequencer that loses the arm bit, serves channels in the wrong order or misses a timeout becomes visible within one burst, either through the order of results, a missing or unexpected interrupt, or the timeout flag. Bad prescaler state appears as request spacing or timeout latency outside a window of one tick.

// File: rtl/avc_pkg.sv
package avc_pkg;
  localparam int CH_STRIDE  = 32'h20;
  localparam int CFG2_OFS   = 32'h10;
  localparam int TIMER_ADR  = 32'h90;
  localparam int SIGEN_ADR  = 32'hC0;
  localparam int INTEN_ADR  = 32'hD0;
  localparam int STAT_ADR   = 32'hE0;
  localparam int RES01_ADR  = 32'hF0;
  localparam int RES23_ADR  = 32'h100;
  localparam int GLOB_ADR   = 32'h130;
  localparam int DONE_LSB   = 8;
  localparam int TMO_LSB    = 16;
  localparam int MAX_PDIV   = 5;
  localparam int MAX_LOG    = 5;

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_GAP, S_FIN} seq_state_e;

  typedef struct packed {
    logic       arm;
    logic       single;
    logic       avg;
    logic [3:0] sel;
    logic [1:0] num;
  } ch_cfg_t;
endpackage

// File: rtl/avc_tick_gen.sv
module avc_tick_gen #(
  parameter int PDIV_W   = 3,
  parameter int MAX_CODE = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [PDIV_W-1:0] code_i,
  output logic              tick_o
);
  localparam int CNT_W = MAX_CODE + 3;

  logic [CNT_W-1:0]  cnt_q, lim;
  logic [PDIV_W-1:0] code_eff;

  always_comb begin
    code_eff = (code_i > PDIV_W'(MAX_CODE)) ? PDIV_W'(MAX_CODE) : code_i;
    lim      = (CNT_W'(4) << code_eff) - CNT_W'(1);
    tick_o   = (cnt_q >= lim);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (tick_o) cnt_q <= '0;
    else             cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/avc_accum.sv
module avc_accum #(
  parameter int SMP_W   = 12,
  parameter int MAX_LOG = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             add_i,
  input  logic [SMP_W-1:0] data_i,
  input  logic [2:0]       shift_i,
  output logic [SMP_W-1:0] mean_o
);
  localparam int ACC_W = SMP_W + MAX_LOG;

  logic [ACC_W-1:0] acc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     acc_q <= '0;
    else if (clr_i)  acc_q <= '0;
    else if (add_i)  acc_q <= acc_q + ACC_W'(data_i);
  end

  assign mean_o = SMP_W'(acc_q >> shift_i);
endmodule

// File: rtl/avc_seq.sv
module avc_seq
  import avc_pkg::*;
#(
  parameter int NCH       = 4,
  parameter int SEL_W     = 4,
  parameter int TU_W      = 8,
  parameter int TMO_TICKS = 16,
  localparam int CH_W     = $clog2(NCH)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      tick_i,
  input  logic                      go_i,
  input  logic [NCH-1:0]            elig_i,
  input  logic [NCH-1:0][SEL_W-1:0] sel_i,
  input  logic [NCH-1:0][2:0]       shift_i,
  input  logic [TU_W-1:0]           tu_i,
  input  logic                      ack_i,
  output logic                      req_o,
  output logic [SEL_W-1:0]          sel_o,
  output logic [2:0]                shift_o,
  output logic                      acc_clr_o,
  output logic                      acc_add_o,
  output logic                      done_o,
  output logic                      tmo_o,
  output logic                      busy_o,
  output logic [CH_W-1:0]           ch_o
);
  localparam int LEFT_W = MAX_LOG + 2;
  localparam int WAIT_W = $clog2(TMO_TICKS + 1);
  localparam int PACE_W = TU_W + 3;

  seq_state_e        st_q;
  logic [CH_W-1:0]   ch_q, pick;
  logic [SEL_W-1:0]  sel_q;
  logic [2:0]        shift_q;
  logic [LEFT_W-1:0] left_q;
  logic [WAIT_W-1:0] wait_q;
  logic [PACE_W-1:0] gap_q, pace;
  logic              start;

  always_comb begin
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--) if (elig_i[c]) pick = CH_W'(c);
  end

  assign pace      = (PACE_W'(tu_i) + PACE_W'(1)) * PACE_W'(6);
  assign start     = (st_q == S_IDLE) && go_i && (|elig_i);
  assign req_o     = (st_q == S_REQ);
  assign acc_clr_o = start;
  assign acc_add_o = req_o && ack_i;
  assign tmo_o     = req_o && !ack_i && tick_i && (wait_q == WAIT_W'(TMO_TICKS - 1));
  assign done_o    = (st_q == S_FIN);
  assign busy_o    = (st_q != S_IDLE);
  assign ch_o      = ch_q;
  assign sel_o     = sel_q;
  assign shift_o   = shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= S_IDLE;
      ch_q    <= '0;
      sel_q   <= '0;
      shift_q <= '0;
      left_q  <= '0;
      wait_q  <= '0;
      gap_q   <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (start) begin
          ch_q    <= pick;
          sel_q   <= sel_i[pick];
          shift_q <= shift_i[pick];
          left_q  <= LEFT_W'(1) << shift_i[pick];
          wait_q  <= '0;
          st_q    <= S_REQ;
        end
        S_REQ: begin
          if (ack_i) begin
            left_q <= left_q - LEFT_W'(1);
            gap_q  <= '0;
            st_q   <= (left_q == LEFT_W'(1)) ? S_FIN : S_GAP;
          end else if (tmo_o) begin
            st_q <= S_IDLE;
          end else if (tick_i) begin
            wait_q <= wait_q + WAIT_W'(1);
          end
        end
        S_GAP: if (tick_i) begin
          if (gap_q == pace - PACE_W'(1)) begin
            wait_q <= '0;
            st_q   <= S_REQ;
          end else begin
            gap_q <= gap_q + PACE_W'(1);
          end
        end
        S_FIN: st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/avg_adc_ctrl.sv
module avg_adc_ctrl
  import avc_pkg::*;
#(
  parameter int ADDR_W    = 9,
  parameter int SMP_W     = 12,
  parameter int TU_W      = 8,
  parameter int TMO_TICKS = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  output logic              smp_req_o,
  output logic [3:0]        smp_sel_o,
  input  logic              smp_ack_i,
  input  logic [SMP_W-1:0]  smp_data_i,
  output logic              irq_o
);
  localparam int NCH   = 4;
  localparam int CH_W  = $clog2(NCH);
  localparam int SEL_W = 4;

  logic [31:0]        adr;
  ch_cfg_t            cfg_q [NCH];
  logic [SMP_W-1:0]   res_q [NCH];
  logic [2:0]         pdiv_q;
  logic [TU_W-1:0]    tu_q;
  logic [NCH-1:0]     sig_en_q, int_en_q, done_q, tmo_q, elig;
  logic               g_en_q, g_pd_q, g_cd_q, glob_ok, stat_we;
  logic [NCH-1:0][SEL_W-1:0] ch_sel;
  logic [NCH-1:0][2:0]       ch_shift;

  logic             tick, seq_done, seq_tmo, seq_busy, acc_clr, acc_add;
  logic [2:0]       cur_shift;
  logic [CH_W-1:0]  seq_ch;
  logic [SMP_W-1:0] mean;

  assign adr     = 32'(bus_addr_i);
  assign stat_we = bus_we_i && (adr == STAT_ADR);
  assign glob_ok = g_en_q && !g_pd_q && !g_cd_q;

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    logic wr1, wr2, hw_clr;
    assign wr1    = bus_we_i && (adr == g * CH_STRIDE);
    assign wr2    = bus_we_i && (adr == g * CH_STRIDE + CFG2_OFS);
    assign hw_clr = (seq_done || seq_tmo) && (seq_ch == CH_W'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) cfg_q[g] <= '0;
      else begin
        if (wr1) begin
          cfg_q[g].arm    <= bus_wdata_i[31];
          cfg_q[g].single <= bus_wdata_i[30];
          cfg_q[g].avg    <= bus_wdata_i[29];
          cfg_q[g].sel    <= bus_wdata_i[27:24];
        end
        if (wr2)    cfg_q[g].num <= bus_wdata_i[13:12];
        if (hw_clr) cfg_q[g].arm <= 1'b0;  // hardware clear wins
      end
    end

    assign elig[g]     = cfg_q[g].arm && cfg_q[g].single;
    assign ch_sel[g]   = cfg_q[g].sel;
    assign ch_shift[g] = cfg_q[g].avg ? (3'(cfg_q[g].num) + 3'd2) : 3'd0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pdiv_q   <= '0;
      tu_q     <= '0;
      sig_en_q <= '0;
      int_en_q <= '0;
      g_en_q   <= 1'b0;
      g_pd_q   <= 1'b1;
      g_cd_q   <= 1'b1;
    end else if (bus_we_i) begin
      if (adr == TIMER_ADR) begin
        pdiv_q <= bus_wdata_i[31:29];
        tu_q   <= bus_wdata_i[TU_W-1:0];
      end
      if (adr == SIGEN_ADR) sig_en_q <= bus_wdata_i[DONE_LSB +: NCH];
      if (adr == INTEN_ADR) int_en_q <= bus_wdata_i[DONE_LSB +: NCH];
      if (adr == GLOB_ADR) begin
        g_en_q <= bus_wdata_i[0];
        g_pd_q <= bus_wdata_i[1];
        g_cd_q <= bus_wdata_i[31];
      end
    end
  end

  // status: write-zero-to-clear, hardware set has priority
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      done_q <= '0;
      tmo_q  <= '0;
      for (int c = 0; c < NCH; c++) res_q[c] <= '0;
    end else begin
      if (stat_we) begin
        done_q <= done_q & bus_wdata_i[DONE_LSB +: NCH];
        tmo_q  <= tmo_q  & bus_wdata_i[TMO_LSB +: NCH];
      end
      if (seq_done) begin
        done_q[seq_ch] <= 1'b1;
        res_q[seq_ch]  <= mean;
      end
      if (seq_tmo) tmo_q[seq_ch] <= 1'b1;
    end
  end

  assign irq_o = |((done_q | tmo_q) & sig_en_q & int_en_q);

  always_comb begin
    bus_rdata_o = '0;
    for (int c = 0; c < NCH; c++) begin
      if (adr == c * CH_STRIDE)
        bus_rdata_o = {cfg_q[c].arm, cfg_q[c].single, cfg_q[c].avg, 1'b0, cfg_q[c].sel, 24'b0};
      if (adr == c * CH_STRIDE + CFG2_OFS)
        bus_rdata_o = {18'b0, cfg_q[c].num, 12'b0};
    end
    case (adr)
      TIMER_ADR: bus_rdata_o = {pdiv_q, 29'(tu_q)};
      SIGEN_ADR: bus_rdata_o = 32'(sig_en_q) << DONE_LSB;
      INTEN_ADR: bus_rdata_o = 32'(int_en_q) << DONE_LSB;
      STAT_ADR:  bus_rdata_o = (32'(tmo_q) << TMO_LSB) | (32'(done_q) << DONE_LSB);
      RES01_ADR: bus_rdata_o = {16'(res_q[1]), 16'(res_q[0])};
      RES23_ADR: bus_rdata_o = {16'(res_q[3]), 16'(res_q[2])};
      GLOB_ADR:  bus_rdata_o = {g_cd_q, 29'b0, g_pd_q, g_en_q};
      default: ;
    endcase
  end

  avc_tick_gen #(.PDIV_W(3), .MAX_CODE(MAX_PDIV)) u_tick (
    .clk_i, .rst_ni, .code_i(pdiv_q), .tick_o(tick)
  );

  avc_seq #(.NCH(NCH), .SEL_W(SEL_W), .TU_W(TU_W), .TMO_TICKS(TMO_TICKS)) u_seq (
    .clk_i, .rst_ni, .tick_i(tick), .go_i(glob_ok), .elig_i(elig),
    .sel_i(ch_sel), .shift_i(ch_shift), .tu_i(tu_q), .ack_i(smp_ack_i),
    .req_o(smp_req_o), .sel_o(smp_sel_o), .shift_o(cur_shift),
    .acc_clr_o(acc_clr), .acc_add_o(acc_add), .done_o(seq_done),
    .tmo_o(seq_tmo), .busy_o(seq_busy), .ch_o(seq_ch)
  );

  avc_accum #(.SMP_W(SMP_W), .MAX_LOG(MAX_LOG)) u_acc (
    .clk_i, .rst_ni, .clr_i(acc_clr), .add_i(acc_add), .data_i(smp_data_i),
    .shift_i(cur_shift), .mean_o(mean)
  );
endmodule

// File: rtl/avc_chk.sv
module avc_chk #(
  parameter int NCH  = 4,
  parameter int CH_W = 2
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            smp_req_o,
  input logic            smp_ack_i,
  input logic [3:0]      smp_sel_o,
  input logic            irq_o,
  input logic            stat_we,
  input logic [NCH-1:0]  done_q,
  input logic [NCH-1:0]  tmo_q,
  input logic [NCH-1:0]  sig_en_q,
  input logic [NCH-1:0]  int_en_q,
  input logic [NCH-1:0]  elig,
  input logic            glob_ok,
  input logic            seq_busy,
  input logic            seq_done,
  input logic            seq_tmo,
  input logic [CH_W-1:0] seq_ch
);
  logic [NCH-1:0] below;
  assign below = NCH'((1 << seq_ch) - 1);

  a_r2_start_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_busy) |-> $past(glob_ok));

  a_r6_done_disarms: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_done |=> (done_q[$past(seq_ch)] && !elig[$past(seq_ch)]));

  a_r7_flags_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stat_we |=> ((($past(done_q) & ~done_q) | ($past(tmo_q) & ~tmo_q)) == '0));

  a_r8_irq_gated: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|((done_q | tmo_q) & sig_en_q & int_en_q)));

  a_r9_lowest_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(seq_busy) |-> (($past(elig) & below) == '0));

  a_r10_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (smp_req_o && !smp_ack_i && !seq_tmo) |=> (smp_req_o && $stable(smp_sel_o)));
endmodule

bind avg_adc_ctrl avc_chk #(.NCH(4), .CH_W(2)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .smp_req_o(smp_req_o), .smp_ack_i(smp_ack_i),
  .smp_sel_o(smp_sel_o), .irq_o(irq_o), .stat_we(stat_we), .done_q(done_q),
  .tmo_q(tmo_q), .sig_en_q(sig_en_q), .int_en_q(int_en_q), .elig(elig),
  .glob_ok(glob_ok), .seq_busy(seq_busy), .seq_done(seq_done),
  .seq_tmo(seq_tmo), .seq_ch(seq_ch)
);

// File: tb/sim_avg_adc_ctrl.sv
`timescale 1ns/1ps
module sim_avg_adc_ctrl;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        we = 1'b0;
  logic [8:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        req, ack, irq;
  logic [3:0]  sel;
  logic [11:0] sdata;

  always #2 clk = ~clk;

  avg_adc_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .bus_we_i(we), .bus_addr_i(addr),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .smp_req_o(req),
    .smp_sel_o(sel), .smp_ack_i(ack), .smp_data_i(sdata), .irq_o(irq)
  );

  int n_chk = 0, n_fail = 0;
  int cyc = 0, req_rises = 0, smp_idx = 0, next_idx = 0;
  logic mute = 1'b0, prev_req = 1'b0, mon_on = 1'b0, mon_busy = 1'b0;
  logic [2:0] dly;
  int rise_t[$];

  typedef struct { int ch; int val; } exp_t;
  exp_t sb[$];
  int last_res[4] = '{0, 0, 0, 0};

  function automatic int smp_val(int s, int i);
    return (s * 211 + i * 37) % 4096;
  endfunction

  // converter core model: acknowledge 4 cycles after request
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst_n) begin ack <= 1'b0; dly <= '0; sdata <= '0; end
    else if (ack) begin ack <= 1'b0; dly <= '0; end
    else if (req && !mute) begin
      if (dly == 3'd3) begin
        ack <= 1'b1; sdata <= 12'(smp_val(int'(sel), smp_idx)); smp_idx <= smp_idx + 1;
      end else dly <= dly + 3'd1;
    end
  end

  always @(negedge clk) begin
    prev_req <= req;
    if (req && !prev_req) begin req_rises <= req_rises + 1; rise_t.push_back(cyc); end
  end

  task automatic chk(bit ok, string r, longint act, longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  task automatic bus_wr(int a, logic [31:0] d);
    @(negedge clk); we = 1'b1; addr = 9'(a); wdata = d;
    @(negedge clk); we = 1'b0;
  endtask

  task automatic bus_rd(int a, output logic [31:0] d);
    @(negedge clk); we = 1'b0; addr = 9'(a); #1 d = rdata;
  endtask

  function automatic int mean_of(int s, int start, int n);
    int sum = 0, sh = 0;
    for (int i = 0; i < n; i++) sum += smp_val(s, start + i);
    while ((1 << sh) < n) sh++;
    return (sum >> sh) & 12'hFFF;
  endfunction

  // driver: push expected result, then arm the channel
  task automatic launch(int ch, int s, bit avg, int code, bit arm_now = 1);
    int n = avg ? (4 << code) : 1;
    exp_t e;
    e.ch = ch; e.val = mean_of(s, next_idx, n);
    next_idx += n; last_res[ch] = e.val;
    sb.push_back(e);
    bus_wr(ch * 32'h20 + 32'h10, 32'(code) << 12);
    if (arm_now) bus_wr(ch * 32'h20, 32'hC000_0000 | (32'(avg) << 29) | (32'(s) << 24));
  endtask

  task automatic drain();
    wait (sb.size() == 0 && !mon_busy);
    @(negedge clk);
  endtask

  // monitor: on interrupt read status, compare result with scoreboard head
  initial begin
    logic [31:0] st, rv;
    forever begin
      @(negedge clk);
      if (mon_on && irq) begin
        mon_busy = 1'b1;
        bus_rd(32'hE0, st);
        for (int c = 0; c < 4; c++) begin
          if (st[8 + c]) begin
            exp_t e;
            bus_rd(c < 2 ? 32'hF0 : 32'h100, rv);
            if (sb.size() == 0) chk(0, "R3 unexpected done", c, -1);
            else begin
              e = sb.pop_front();
              chk(e.ch == c, "R9 service order", c, e.ch);
              chk(int'((rv >> ((c % 2) * 16)) & 32'hFFF) == e.val, "R3 averaged result",
                  (rv >> ((c % 2) * 16)) & 32'hFFF, e.val);
            end
            bus_wr(32'hE0, ~(32'h1 << (8 + c)));
            break;
          end
        end
        mon_busy = 1'b0;
      end
    end
  end

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=running expected=finished");
    report();
  end

  initial begin
    logic [31:0] v, v2;
    int t0, rq;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    bus_rd(32'h130, v); chk(v == 32'h8000_0002, "R1 global reset", v, 32'h8000_0002);
    bus_rd(32'hE0, v);  chk(v == 0, "R1 status reset", v, 0);
    bus_rd(32'hF0, v);  chk(v == 0, "R1 result01 reset", v, 0);
    bus_rd(32'h100, v); chk(v == 0, "R1 result23 reset", v, 0);
    chk(irq == 1'b0, "R1 irq reset", irq, 0);

    bus_wr(32'h90, 32'h0);
    bus_wr(32'hC0, 32'hF00);
    bus_wr(32'hD0, 32'hF00);

    // R2 held off while powered down, then 4-sample burst once enabled
    mon_on = 1'b1;
    launch(0, 3, 1, 0);
    repeat (100) @(negedge clk);
    chk(req_rises == 0, "R2 no request while powered down", req_rises, 0);
    bus_rd(32'h00, v); chk(v[31] == 1'b1, "R2 channel stays armed", v[31], 1);
    bus_wr(32'h130, 32'h8000_0001);
    repeat (100) @(negedge clk);
    chk(req_rises == 0, "R2 no request while clock-down", req_rises, 0);
    bus_wr(32'h130, 32'h1);
    drain();
    bus_rd(32'h00, v); chk(v[31] == 1'b0, "R6 arm bit cleared", v[31], 0);

    // R3 other averaging depths on other channels
    launch(1, 7, 1, 1); drain();
    launch(2, 12, 1, 2); drain();
    launch(3, 15, 1, 3); drain();
    // R4 single sample
    launch(0, 9, 0, 2); drain();

    // R5 packing
    bus_rd(32'hF0, v);
    chk(v == ((32'(last_res[1]) << 16) | 32'(last_res[0])), "R5 channels 0/1 packing", v,
        (32'(last_res[1]) << 16) | 32'(last_res[0]));
    bus_rd(32'h100, v);
    chk(v == ((32'(last_res[3]) << 16) | 32'(last_res[2])), "R5 channels 2/3 packing", v,
        (32'(last_res[3]) << 16) | 32'(last_res[2]));

    // R7 read does not clear; write 1 keeps; write 0 clears
    mon_on = 1'b0;
    launch(2, 5, 1, 0);
    void'(sb.pop_back());
    wait (irq); @(negedge clk);
    bus_rd(32'hE0, v); bus_rd(32'hE0, v2);
    chk(v2 == 32'h400 && v == v2, "R7 status survives reads", v2, 32'h400);
    bus_rd(32'h100, v); chk(int'(v & 32'hFFF) == last_res[2], "R6 result stored", v & 32'hFFF, last_res[2]);
    // R8 gating by both enables
    bus_wr(32'hC0, 32'hB00); chk(irq == 1'b0, "R8 signal enable masks", irq, 0);
    bus_wr(32'hC0, 32'hF00); chk(irq == 1'b1, "R8 both enables", irq, 1);
    bus_wr(32'hD0, 32'hB00); chk(irq == 1'b0, "R8 interrupt enable masks", irq, 0);
    bus_wr(32'hD0, 32'hF00);
    bus_wr(32'hE0, 32'hFFFF_FFFF);
    bus_rd(32'hE0, v); chk(v == 32'h400, "R7 writing ones keeps flag", v, 32'h400);
    bus_wr(32'hE0, 32'hFFFF_FBFF);
    bus_rd(32'hE0, v); chk(v == 0, "R7 writing zero clears flag", v, 0);
    chk(irq == 1'b0, "R8 irq drops with flag", irq, 0);

    // R9 two channels armed together: channel 0 before channel 3
    bus_wr(32'h130, 32'h0);
    mon_on = 1'b1;
    launch(0, 2, 1, 0, 0);
    launch(3, 11, 1, 1, 0);
    bus_wr(32'h60, 32'hE000_0000 | (32'd11 << 24));
    bus_wr(32'h00, 32'hE000_0000 | (32'd2 << 24));
    bus_wr(32'h130, 32'h1);
    drain();

    // R10 timeout with divide-by-8 ticks
    mon_on = 1'b0; mute = 1'b1;
    bus_wr(32'h90, 32'h2000_0000);
    rise_t.delete();
    bus_wr(32'h20, 32'hE000_0000 | (32'd4 << 24));
    wait (rise_t.size() > 0);
    t0 = rise_t[0];
    wait (irq); @(negedge clk);
    chk((cyc - t0) >= 118 && (cyc - t0) <= 132, "R10/R11 timeout after 16 ticks of 8", cyc - t0, 128);
    bus_rd(32'hE0, v); chk(v == 32'h2_0000, "R10 timeout flag only", v, 32'h2_0000);
    bus_rd(32'h20, v); chk(v[31] == 1'b0, "R10 arm bit cleared", v[31], 0);
    bus_rd(32'hF0, v); chk(int'(v[27:16]) == last_res[1], "R10 result untouched", v[27:16], last_res[1]);
    bus_wr(32'hE0, 32'h0);
    mute = 1'b0;

    // R11 pacing with unit value 1 at divide-by-4: 12 ticks = 48 cycles
    bus_wr(32'h90, 32'h1);
    mon_on = 1'b1;
    rise_t.delete();
    launch(1, 6, 1, 0);
    drain();
    rq = rise_t.size();
    chk(rq == 4, "R11 request count", rq, 4);
    for (int i = 1; i < rq; i++)
      chk((rise_t[i] - rise_t[i-1]) >= 44 && (rise_t[i] - rise_t[i-1]) <= 60,
          "R11 request spacing", rise_t[i] - rise_t[i-1], 52);

    repeat (10) @(negedge clk);
    chk(sb.size() == 0, "R3 scoreboard empty", sb.size(), 0);
    report();
  end
endmodule